// File: doc/BRIEF.md
# Cross-Clock Mailbox Bypass Register

This block carries single words from a sending clock domain to a receiving clock domain outside the queue datapath. When the sender raises its enable together with the mailbox-select input, the word on its data bus is stored in a 36-bit holding register rather than being queued. The receiver then sees a mail-present flag. A receiving read with mailbox select asserted clears that flag. While mailbox select is asserted, the receive data bus shows the held word instead of the queue output.

The set and clear events cross the clock boundary as level toggles through multi-stage synchronizers. The sender keeps a local busy view that stays high from an accepted write until the receiver's clear has returned to the sending domain. While busy is high, mailbox writes are dropped, so unread mail is never overwritten and the held word never changes while the receiver samples it. Neither side has a ready signal. The sender applies back-pressure itself: it must watch `w_busy` and retry once it falls. The receiver watches `r_mail` and reads when it chooses. One active-low reset, shared with the queue that serves the same direction, clears the held word and both flag views.

Top module: `mbx_bypass`

## Requirements
- R1: While reset is applied and after it is released, `r_mail` and `w_busy` are 0, and the held word is all zeros, so `r_data` reads 0 with `r_mbox_sel` high.
- R2: A sending edge with `w_en`=1, `w_mbox_sel`=1 and `w_busy`=0 stores `w_data` in the mailbox, and `w_busy` is 1 after that edge.
- R3: A sending edge with `w_en`=1 and `w_mbox_sel`=0 leaves the held word, `w_busy` and `r_mail` unchanged.
- R4: After an accepted write, `r_mail` goes high no later than the third receiving clock edge (SYNC_STAGES+1 with the default of 2).
- R5: `r_data` equals the held word while `r_mbox_sel`=1, and equals `r_fifo_data` while `r_mbox_sel`=0.
- R6: A receiving edge with `r_en`=1, `r_mbox_sel`=1 and `r_mail`=1 makes `r_mail` 0 after that edge.
- R7: A mailbox write while `w_busy`=1 is dropped. The held word keeps its value and `w_busy` stays 1.
- R8: After the clearing read, `w_busy` returns to 0 within six sending clock cycles, and a new write is then accepted.
- R9: A receiving mailbox read while `r_mail`=0 has no effect. The flag stays 0, and the next write sets it as usual.
- R10: Once set, `r_mail` stays 1 until a receiving edge has `r_en`=1 and `r_mbox_sel`=1. This includes edges with `r_en`=1 and `r_mbox_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_w | input | 1 | Sending-domain clock |
| clk_r | input | 1 | Receiving-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset, shared with the queue of this direction |
| w_en | input | 1 | Sending write enable |
| w_mbox_sel | input | 1 | Steers an enabled write into the mailbox |
| w_data | input | 36 | Sending data word |
| w_busy | output | 1 | Sending view: mail is not yet acknowledged, so writes are dropped |
| r_en | input | 1 | Receiving read enable |
| r_mbox_sel | input | 1 | Selects the mailbox for the read and for `r_data` |
| r_fifo_data | input | 36 | Queue output word to pass through when the mailbox is not selected |
| r_data | output | 36 | Receiving data bus |
| r_mail | output | 1 | Receiving view: new mail is waiting |

## Verification
A walking-one word and its complement, followed by a set of mixed words, are each sent through the full cycle of write, flag, read and busy release. This separates a stuck or swapped data bit from a handshake fault. For every word, a complemented overwrite is attempted while the mail is pending. A mismatch there exposes a missing busy guard rather than a synchronizer fault. Writes without select, reads without mail, and enabled reads without select are mixed in to show that the flag and the held word react only to the qualified events. The receive-edge count from write to flag bounds the synchronizer depth.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned MBX_DATA_W_DEF = 36;
  localparam int unsigned MBX_SYNC_DEF   = 2;

  // Qualified request: enable and mailbox select together.
  function automatic logic mbx_hit(input logic en, input logic sel);
    return en & sel;
  endfunction
endpackage

// File: rtl/mbx_tgl_sync.sv
module mbx_tgl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[s] <= 1'b0;
        else        chain_q[s] <= chain_q[s-1];
      end
    end
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_send.sv
module mbx_send
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = MBX_DATA_W_DEF,
  parameter int unsigned STAGES = MBX_SYNC_DEF
) (
  input  logic              clk_w,
  input  logic              rst_n,
  input  logic              w_en,
  input  logic              w_mbox_sel,
  input  logic [DATA_W-1:0] w_data,
  input  logic              clr_tgl,
  output logic [DATA_W-1:0] mbox_q,
  output logic              set_tgl,
  output logic              busy
);
  logic clr_seen;
  logic accept;

  mbx_tgl_sync #(.STAGES(STAGES)) u_clr_sync (
    .clk(clk_w), .rst_n(rst_n), .d(clr_tgl), .q(clr_seen)
  );

  // Sent toggles minus returned toggles: one outstanding mail at most.
  assign busy   = set_tgl ^ clr_seen;
  assign accept = mbx_hit(w_en, w_mbox_sel) & ~busy;

  always_ff @(posedge clk_w or negedge rst_n) begin
    if (!rst_n) begin
      set_tgl <= 1'b0;
      mbox_q  <= '0;
    end else if (accept) begin
      set_tgl <= ~set_tgl;
      mbox_q  <= w_data;
    end
  end
endmodule

// File: rtl/mbx_recv.sv
module mbx_recv
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W = MBX_DATA_W_DEF,
  parameter int unsigned STAGES = MBX_SYNC_DEF
) (
  input  logic              clk_r,
  input  logic              rst_n,
  input  logic              r_en,
  input  logic              r_mbox_sel,
  input  logic              set_tgl,
  input  logic [DATA_W-1:0] mbox_q,
  input  logic [DATA_W-1:0] r_fifo_data,
  output logic [DATA_W-1:0] r_data,
  output logic              r_mail,
  output logic              clr_tgl
);
  logic set_seen;

  mbx_tgl_sync #(.STAGES(STAGES)) u_set_sync (
    .clk(clk_r), .rst_n(rst_n), .d(set_tgl), .q(set_seen)
  );

  assign r_mail = set_seen ^ clr_tgl;

  always_ff @(posedge clk_r or negedge rst_n) begin
    if (!rst_n)                                   clr_tgl <= 1'b0;
    else if (mbx_hit(r_en, r_mbox_sel) && r_mail) clr_tgl <= ~clr_tgl;
  end

  // The held word is stable whenever r_mail is high (sender is busy).
  assign r_data = r_mbox_sel ? mbox_q : r_fifo_data;
endmodule

// File: rtl/mbx_bypass.sv
module mbx_bypass
  import mbx_pkg::*;
#(
  parameter int unsigned DATA_W      = MBX_DATA_W_DEF,
  parameter int unsigned SYNC_STAGES = MBX_SYNC_DEF
) (
  input  logic              clk_w,
  input  logic              clk_r,
  input  logic              rst_n,
  input  logic              w_en,
  input  logic              w_mbox_sel,
  input  logic [DATA_W-1:0] w_data,
  output logic              w_busy,
  input  logic              r_en,
  input  logic              r_mbox_sel,
  input  logic [DATA_W-1:0] r_fifo_data,
  output logic [DATA_W-1:0] r_data,
  output logic              r_mail
);
  logic [DATA_W-1:0] mbox_q;
  logic              set_tgl;
  logic              clr_tgl;

  mbx_send #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_send (
    .clk_w(clk_w), .rst_n(rst_n), .w_en(w_en), .w_mbox_sel(w_mbox_sel),
    .w_data(w_data), .clr_tgl(clr_tgl), .mbox_q(mbox_q),
    .set_tgl(set_tgl), .busy(w_busy)
  );

  mbx_recv #(.DATA_W(DATA_W), .STAGES(SYNC_STAGES)) u_recv (
    .clk_r(clk_r), .rst_n(rst_n), .r_en(r_en), .r_mbox_sel(r_mbox_sel),
    .set_tgl(set_tgl), .mbox_q(mbox_q), .r_fifo_data(r_fifo_data),
    .r_data(r_data), .r_mail(r_mail), .clr_tgl(clr_tgl)
  );
endmodule

// File: rtl/mbx_bypass_chk.sv
module mbx_bypass_chk #(
  parameter int unsigned DATA_W = 36
) (
  input logic              clk_w,
  input logic              clk_r,
  input logic              rst_n,
  input logic              w_en,
  input logic              w_mbox_sel,
  input logic [DATA_W-1:0] w_data,
  input logic              w_busy,
  input logic              r_en,
  input logic              r_mbox_sel,
  input logic              r_mail,
  input logic [DATA_W-1:0] mbox_q
);
  assert_accept_R2: assert property (@(posedge clk_w) disable iff (!rst_n)
    (!w_busy && w_en && w_mbox_sel) |=> (w_busy && mbox_q == $past(w_data)));

  assert_no_overwrite_R7: assert property (@(posedge clk_w) disable iff (!rst_n)
    (w_busy && w_en && w_mbox_sel) |=> $stable(mbox_q));

  assert_sel_low_keeps_R3: assert property (@(posedge clk_w) disable iff (!rst_n)
    (w_en && !w_mbox_sel) |=> $stable(mbox_q));

  assert_read_clears_R6: assert property (@(posedge clk_r) disable iff (!rst_n)
    (r_mail && r_en && r_mbox_sel) |=> !r_mail);

  assert_flag_holds_R10: assert property (@(posedge clk_r) disable iff (!rst_n)
    (r_mail && !(r_en && r_mbox_sel)) |=> r_mail);

  assert_flag_needs_mail_R4: assert property (@(posedge clk_r) disable iff (!rst_n)
    $rose(r_mail) |-> w_busy);
endmodule

bind mbx_bypass mbx_bypass_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_w(clk_w), .clk_r(clk_r), .rst_n(rst_n), .w_en(w_en),
  .w_mbox_sel(w_mbox_sel), .w_data(w_data), .w_busy(w_busy),
  .r_en(r_en), .r_mbox_sel(r_mbox_sel), .r_mail(r_mail), .mbox_q(mbox_q)
);

// File: tb/mbx_bypass_tb.sv
`timescale 1ns/1ps
module mbx_bypass_tb;
  localparam int W = 36;

  logic clk_w = 0, clk_r = 0, rst_n = 0;
  logic w_en = 0, w_mbox_sel = 0, r_en = 0, r_mbox_sel = 0;
  logic [W-1:0] w_data = '0, r_fifo_data = '0;
  logic [W-1:0] r_data;
  logic w_busy, r_mail;
  int checks = 0, errors = 0;

  always #5 clk_w = ~clk_w;
  always #7 clk_r = ~clk_r;

  mbx_bypass u_dut (
    .clk_w(clk_w), .clk_r(clk_r), .rst_n(rst_n), .w_en(w_en),
    .w_mbox_sel(w_mbox_sel), .w_data(w_data), .w_busy(w_busy),
    .r_en(r_en), .r_mbox_sel(r_mbox_sel), .r_fifo_data(r_fifo_data),
    .r_data(r_data), .r_mail(r_mail)
  );

  task automatic chk(input logic ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Mailbox write attempt; returns receive edges until the flag rose (0 if none).
  task automatic send(input logic [W-1:0] d, input logic sel, output int n);
    n = 0;
    @(negedge clk_w);
    w_en = 1; w_mbox_sel = sel; w_data = d;
    @(posedge clk_w);
    fork begin @(negedge clk_w); w_en = 0; w_mbox_sel = 0; end join_none
    for (int k = 1; k <= 5; k++) begin
      @(posedge clk_r); #1;
      if (r_mail && n == 0) n = k;
    end
  endtask

  task automatic full_cycle(input logic [W-1:0] d);
    int n;
    send(d, 1'b1, n);
    chk(w_busy == 1, "R2 busy after write", 64'(w_busy), 64'd1);
    chk(n >= 1 && n <= 3, "R4 flag latency", 64'(n), 64'd3);
    r_mbox_sel = 1; #1;
    chk(r_data == d, "R2/R5 mailbox word", 64'(r_data), 64'(d));
    // overwrite attempt while pending
    @(negedge clk_w); w_en = 1; w_mbox_sel = 1; w_data = ~d;
    @(negedge clk_w); w_en = 0; w_mbox_sel = 0;
    chk(r_data == d && w_busy, "R7 overwrite dropped", 64'(r_data), 64'(d));
    // enabled reads without select must not clear
    r_mbox_sel = 0; r_fifo_data = d ^ 36'h5A5A5A5A5;
    @(negedge clk_r); r_en = 1;
    #1 chk(r_data == (d ^ 36'h5A5A5A5A5), "R5 pass-through", 64'(r_data), 64'(d ^ 36'h5A5A5A5A5));
    repeat (3) @(negedge clk_r);
    r_en = 0;
    chk(r_mail == 1, "R10 flag held", 64'(r_mail), 64'd1);
    // clearing read
    @(negedge clk_r); r_en = 1; r_mbox_sel = 1;
    @(posedge clk_r); #1;
    chk(r_mail == 0, "R6 read clears", 64'(r_mail), 64'd0);
    @(negedge clk_r); r_en = 0; r_mbox_sel = 0;
    n = 0;
    for (int k = 1; k <= 8; k++) begin
      @(posedge clk_w); #1;
      if (!w_busy && n == 0) n = k;
    end
    chk(n >= 1 && n <= 6, "R8 busy release", 64'(n), 64'd6);
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [W-1:0] last;
    #3;
    r_mbox_sel = 1; #1;
    chk(!r_mail && !w_busy && r_data == '0, "R1 in reset", {r_mail, w_busy, 26'd0, r_data}, 64'd0);
    repeat (3) @(negedge clk_w);
    rst_n = 1;
    repeat (2) @(negedge clk_r);
    chk(!r_mail && !w_busy && r_data == '0, "R1 after reset", {r_mail, w_busy, 26'd0, r_data}, 64'd0);
    r_mbox_sel = 0;

    for (int b = 0; b < W; b++) full_cycle(36'd1 << b);
    for (int b = 0; b < W; b += 5) full_cycle(~(36'd1 << b));
    for (int i = 0; i < 8; i++) full_cycle(36'(64'h9E3779B97F4A7C15 * (i + 1)));
    last = 36'(64'h9E3779B97F4A7C15 * 8);

    // R3: write without select
    send(36'hABCDE1234, 1'b0, n);
    r_mbox_sel = 1; #1;
    chk(n == 0 && !w_busy && r_data == last, "R3 no select ignored", 64'(r_data), 64'(last));
    r_mbox_sel = 0;

    // R9: read with no mail pending
    @(negedge clk_r); r_en = 1; r_mbox_sel = 1;
    repeat (2) @(negedge clk_r);
    r_en = 0; r_mbox_sel = 0;
    chk(r_mail == 0 && w_busy == 0, "R9 empty read no effect", 64'(r_mail), 64'd0);
    full_cycle(36'h123456789);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule